// File: doc/BRIEF.md
# Advance-Pipe Deferral Issue Controller

This block is the issue stage of the front in-order pipeline in a two-pass machine. Each cycle it is offered one issue group of `GW` slots. Every slot holds:

- an opcode: add, or load;
- source and destination register indices;
- a critical mark set by the compiler;
- for loads, a miss indication and the returned data.

A per-register scoreboard records, for each architectural register, three things: a value, a *pending* bit (waiting for a miss fill) and a *poison* bit (a non-result written by a deferred instruction). A slot whose sources are all usable executes at once, with a small adder standing in for execution. A slot with an unusable source does not stall. Instead it is deferred, and it poisons its destination, so that its consumers are deferred in turn.

Only a critical slot that waits on a pending source holds the group, and with it every later group. Accepted slots enter, in program order, a coupling FIFO that feeds the backup pipeline. A missing load with usable sources is also passed on as deferred, and it marks its destination pending until a fill event for that register arrives.

Group reads are fused: every slot reads the scoreboard as it stood before the group. A group is accepted whole or not at all.

Top module: `adp_issue`

## Requirements
- R1: A valid slot whose sources are neither pending nor poisoned, and which is not a missing load, executes. An add (op=0) reads rs1 and rs2 and yields their sum modulo 2^DW. A load (op=1) reads rs1 only and yields its `slot_ldata`. The destination takes the result, and its pending and poison bits are cleared.
- R2: A valid slot with any read source pending or poisoned, and not stalled, is deferred. Its FIFO entry has the deferred flag set and a result field of 0, and its destination is poisoned, with pending cleared.
- R3: A poisoned source counts as not usable, so a consumer of a deferred result is itself deferred. The poison stays until a later executed write to that register.
- R4: When any valid slot is critical and has a pending source, `grp_ready` is 0. Nothing of that group is pushed and the scoreboard does not change except by fills. A critical slot whose sources are poisoned but not pending is deferred instead of stalling.
- R5: A load with usable sources and `slot_miss`=1 is pushed with the deferred flag set and a result field of 0, and its destination becomes pending. A fill event (`fill_valid`, `fill_reg`, `fill_data`) for a pending register writes the value and clears pending. A fill for a register that is not pending has no effect. A fill is not visible to the group offered in the same cycle.
- R6: All slots of a group read the scoreboard state from before the group. When two slots of a group write the same register, the higher slot index wins.
- R7: A group is accepted (`grp_valid` and `grp_ready`) only if the FIFO has at least GW free entries before this cycle's pop. Its valid slots are pushed in ascending slot order. Each cycle with `q_pop`=1 and a non-empty FIFO removes the oldest entry.
- R8: `q_entry` is, from MSB to LSB: op (1 bit), rd (RW bits), rs1 (RW bits), rs2 (RW bits), deferred flag (1 bit), result (DW bits). `q_valid` is 1 exactly when the FIFO is non-empty.
- R9: After reset the FIFO is empty, and every register is usable with value 0.
- R10: When a fill and an accepted group write the same register in one cycle, the group's write prevails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | Issue group offered |
| slot_vld | input | GW | Per-slot valid |
| slot_op | input | GW | Per-slot opcode, 0 add, 1 load |
| slot_crit | input | GW | Per-slot critical mark |
| slot_miss | input | GW | Per-slot load miss indication |
| slot_rd | input | GW*RW | Destination register indices |
| slot_rs1 | input | GW*RW | First source indices |
| slot_rs2 | input | GW*RW | Second source indices (adds only) |
| slot_ldata | input | GW*DW | Load hit data |
| grp_ready | output | 1 | Group can be accepted this cycle |
| fill_valid | input | 1 | Miss fill event |
| fill_reg | input | RW | Register being filled |
| fill_data | input | DW | Fill value |
| q_pop | input | 1 | Backup pipe takes the head entry |
| q_valid | output | 1 | FIFO head is valid |
| q_entry | output | 2+3*RW+DW | FIFO head entry |

## Verification
The bench builds the block with 8 registers, 16-bit data, two slots and a four-entry FIFO. The small register file makes random sources hit poisoned and pending registers often, and it makes collisions of two slots on one destination frequent. The shallow FIFO means backpressure stalls appear within a few cycles when pops are withheld. Critical stalls on pending sources, same-cycle fills and groups where only some slots are valid all arise in the random phase. Directed sequences pin down the propagation chains first.

// File: rtl/adp_pkg.sv
package adp_pkg;
  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_LOAD = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_EXEC  = 2'd1,
    DEC_DEFER = 2'd2,
    DEC_PEND  = 2'd3
  } dec_e;
endpackage

// File: rtl/adp_slot_eval.sv
module adp_slot_eval
  import adp_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      vld,
  input  logic                      op,
  input  logic                      crit,
  input  logic                      miss,
  input  logic [RW-1:0]             rs1,
  input  logic [RW-1:0]             rs2,
  input  logic [DW-1:0]             ldata,
  input  logic [NREG-1:0][DW-1:0]   rv,
  input  logic [NREG-1:0]           pend,
  input  logic [NREG-1:0]           pois,
  output logic                      stall,
  output logic [1:0]                dec,
  output logic [DW-1:0]             res
);
  logic uses2, spend, spois;

  always_comb begin
    uses2 = (op == OP_ADD);
    spend = pend[rs1] | (uses2 & pend[rs2]);
    spois = pois[rs1] | (uses2 & pois[rs2]);
    stall = vld & crit & spend;
    dec   = DEC_NONE;
    res   = '0;
    if (vld) begin
      if (spend | spois) begin
        dec = DEC_DEFER;
      end else if (op == OP_LOAD && miss) begin
        dec = DEC_PEND;
      end else begin
        dec = DEC_EXEC;
        res = (op == OP_ADD) ? rv[rs1] + rv[rs2] : ldata;
      end
    end
  end
endmodule

// File: rtl/adp_regstate.sv
module adp_regstate
  import adp_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int GW   = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_valid,
  input  logic [RW-1:0]             fill_reg,
  input  logic [DW-1:0]             fill_data,
  input  logic                      accept,
  input  logic [GW-1:0][1:0]        dec,
  input  logic [GW-1:0][RW-1:0]     rd,
  input  logic [GW-1:0][DW-1:0]     res,
  output logic [NREG-1:0][DW-1:0]   rv,
  output logic [NREG-1:0]           pend,
  output logic [NREG-1:0]           pois
);
  logic [NREG-1:0][DW-1:0] rv_n;
  logic [NREG-1:0]         pend_n, pois_n;
  logic                    fill_hit, upd_en;

  always_comb begin
    rv_n     = rv;
    pend_n   = pend;
    pois_n   = pois;
    fill_hit = fill_valid & pend[fill_reg];
    if (fill_hit) begin
      pend_n[fill_reg] = 1'b0;
      rv_n[fill_reg]   = fill_data;
    end
    for (int i = 0; i < GW; i++) begin
      if (accept) begin
        case (dec[i])
          DEC_EXEC: begin
            rv_n[rd[i]]   = res[i];
            pend_n[rd[i]] = 1'b0;
            pois_n[rd[i]] = 1'b0;
          end
          DEC_DEFER: begin
            pend_n[rd[i]] = 1'b0;
            pois_n[rd[i]] = 1'b1;
          end
          DEC_PEND: begin
            pend_n[rd[i]] = 1'b1;
            pois_n[rd[i]] = 1'b0;
          end
          default: ;
        endcase
      end
    end
    upd_en = fill_hit | accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv   <= '0;
      pend <= '0;
      pois <= '0;
    end else if (upd_en) begin
      rv   <= rv_n;
      pend <= pend_n;
      pois <= pois_n;
    end
  end
endmodule

// File: rtl/adp_cfifo.sv
module adp_cfifo #(
  parameter int EW    = 32,
  parameter int DEPTH = 8,
  parameter int GW    = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_en,
  input  logic [GW-1:0]         push_vld,
  input  logic [GW-1:0][EW-1:0] push_data,
  input  logic                  pop,
  output logic                  q_valid,
  output logic [EW-1:0]         q_data,
  output logic                  room,
  output logic [CW-1:0]         count
);
  localparam int unsigned LIM = DEPTH - GW;

  logic [EW-1:0]         mem [DEPTH];
  logic [AW-1:0]         wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0]         count_n, npush;
  logic [GW-1:0][AW-1:0] off;
  logic                  popd, ptr_en;

  always_comb begin
    npush = '0;
    for (int i = 0; i < GW; i++) begin
      off[i] = AW'(npush);
      if (push_en && push_vld[i]) npush = npush + CW'(1);
    end
    popd    = pop && (count != '0);
    wptr_n  = wptr + AW'(npush);
    rptr_n  = rptr + AW'(popd);
    count_n = count + npush - CW'(popd);
    ptr_en  = popd | (npush != '0);
    q_valid = (count != '0);
    q_data  = mem[rptr];
    room    = (count <= CW'(LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (ptr_en) begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < GW; i++) begin
      if (push_en && push_vld[i]) mem[wptr + off[i]] <= push_data[i];
    end
  end
endmodule

// File: rtl/adp_issue.sv
module adp_issue
  import adp_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int DW    = 16,
  parameter int GW    = 2,
  parameter int DEPTH = 8,
  localparam int RW   = $clog2(NREG),
  localparam int EW   = 2 + 3 * RW + DW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grp_valid,
  input  logic [GW-1:0]         slot_vld,
  input  logic [GW-1:0]         slot_op,
  input  logic [GW-1:0]         slot_crit,
  input  logic [GW-1:0]         slot_miss,
  input  logic [GW-1:0][RW-1:0] slot_rd,
  input  logic [GW-1:0][RW-1:0] slot_rs1,
  input  logic [GW-1:0][RW-1:0] slot_rs2,
  input  logic [GW-1:0][DW-1:0] slot_ldata,
  output logic                  grp_ready,
  input  logic                  fill_valid,
  input  logic [RW-1:0]         fill_reg,
  input  logic [DW-1:0]         fill_data,
  input  logic                  q_pop,
  output logic                  q_valid,
  output logic [EW-1:0]         q_entry
);
  logic [1:0]              rst_sync;
  logic                    rst_s_n;
  logic [NREG-1:0][DW-1:0] rv;
  logic [NREG-1:0]         pend, pois;
  logic [GW-1:0]           stall;
  logic [GW-1:0][1:0]      dec;
  logic [GW-1:0][DW-1:0]   res;
  logic [GW-1:0][EW-1:0]   ent;
  logic                    room, accept;
  logic [CW-1:0]           count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  for (genvar g = 0; g < GW; g++) begin : g_slot
    adp_slot_eval #(.NREG(NREG), .DW(DW)) u_eval (
      .vld(slot_vld[g]), .op(slot_op[g]), .crit(slot_crit[g]), .miss(slot_miss[g]),
      .rs1(slot_rs1[g]), .rs2(slot_rs2[g]), .ldata(slot_ldata[g]),
      .rv(rv), .pend(pend), .pois(pois),
      .stall(stall[g]), .dec(dec[g]), .res(res[g])
    );
    assign ent[g] = {slot_op[g], slot_rd[g], slot_rs1[g], slot_rs2[g],
                     (dec[g] != DEC_EXEC), res[g]};
  end

  assign grp_ready = ~(|stall) & room;
  assign accept    = grp_valid & grp_ready;

  adp_regstate #(.NREG(NREG), .DW(DW), .GW(GW)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .fill_valid(fill_valid), .fill_reg(fill_reg), .fill_data(fill_data),
    .accept(accept), .dec(dec), .rd(slot_rd), .res(res),
    .rv(rv), .pend(pend), .pois(pois)
  );

  adp_cfifo #(.EW(EW), .DEPTH(DEPTH), .GW(GW)) u_fifo (
    .clk(clk), .rst_n(rst_s_n),
    .push_en(accept), .push_vld(slot_vld), .push_data(ent),
    .pop(q_pop), .q_valid(q_valid), .q_data(q_entry),
    .room(room), .count(count)
  );
endmodule

// File: rtl/adp_issue_chk.sv
module adp_issue_chk #(
  parameter int NREG  = 16,
  parameter int GW    = 2,
  parameter int DEPTH = 8,
  localparam int RW   = $clog2(NREG),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            grp_valid,
  input logic            grp_ready,
  input logic            fill_valid,
  input logic [RW-1:0]   fill_reg,
  input logic            accept,
  input logic [NREG-1:0] pend,
  input logic [NREG-1:0] pois,
  input logic [CW-1:0]   count
);
  // R5: a register is never both waiting for a fill and poisoned
  p_pend_pois_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & pois) == '0);

  // R7: occupancy never exceeds capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R7: too little room means the group is refused
  p_refuse_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count > CW'(DEPTH - GW)) |-> !grp_ready);

  // R4: a held group changes neither scoreboard nor adds entries
  p_stall_holds_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_ready && !fill_valid) |=>
      ($stable(pend) && $stable(pois) && count <= $past(count)));

  // R5: a fill on a pending register clears it when no group intervenes
  p_fill_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && pend[fill_reg] && !accept) |=> !pend[$past(fill_reg)]);
endmodule

bind adp_issue adp_issue_chk #(.NREG(NREG), .GW(GW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
  .fill_valid(fill_valid), .fill_reg(fill_reg), .accept(accept),
  .pend(pend), .pois(pois), .count(count)
);

// File: tb/adp_issue_test.sv
module adp_issue_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 8;
  localparam int DW    = 16;
  localparam int GW    = 2;
  localparam int DEPTH = 4;
  localparam int RW    = $clog2(NREG);
  localparam int EW    = 2 + 3 * RW + DW;

  logic clk, rst_n;
  logic grp_valid, grp_ready, fill_valid, q_pop, q_valid;
  logic [GW-1:0] s_vld, s_op, s_crit, s_miss;
  logic [GW-1:0][RW-1:0] s_rd, s_rs1, s_rs2;
  logic [GW-1:0][DW-1:0] s_ld;
  logic [RW-1:0] fill_reg;
  logic [DW-1:0] fill_data;
  logic [EW-1:0] q_entry;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_val [NREG];
  bit            m_pend [NREG];
  bit            m_pois [NREG];
  logic [EW-1:0] mq [$];

  adp_issue #(.NREG(NREG), .DW(DW), .GW(GW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid),
    .slot_vld(s_vld), .slot_op(s_op), .slot_crit(s_crit), .slot_miss(s_miss),
    .slot_rd(s_rd), .slot_rs1(s_rs1), .slot_rs2(s_rs2), .slot_ldata(s_ld),
    .grp_ready(grp_ready), .fill_valid(fill_valid), .fill_reg(fill_reg),
    .fill_data(fill_data), .q_pop(q_pop), .q_valid(q_valid), .q_entry(q_entry)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_inputs();
    grp_valid = 0; s_vld = '0; s_op = '0; s_crit = '0; s_miss = '0;
    s_rd = '0; s_rs1 = '0; s_rs2 = '0; s_ld = '0;
    fill_valid = 0; fill_reg = '0; fill_data = '0; q_pop = 1;
  endtask

  task automatic put(input int i, input bit op, input int rd, input int a,
                     input int b, input bit crit, input bit miss, input int ld);
    grp_valid = 1; s_vld[i] = 1; s_op[i] = op; s_rd[i] = RW'(rd);
    s_rs1[i] = RW'(a); s_rs2[i] = RW'(b); s_crit[i] = crit;
    s_miss[i] = miss; s_ld[i] = DW'(ld);
  endtask

  // Inputs are set just after a falling edge; this checks, advances the model,
  // and returns just after the next falling edge.
  task automatic step(input string req);
    bit cs, sp, so, u2, ok;
    int d [GW];
    logic [DW-1:0] r [GW];
    #1;
    cs = 0;
    for (int i = 0; i < GW; i++) begin
      u2 = (s_op[i] == 1'b0);
      sp = m_pend[s_rs1[i]] || (u2 && m_pend[s_rs2[i]]);
      so = m_pois[s_rs1[i]] || (u2 && m_pois[s_rs2[i]]);
      if (s_vld[i] && s_crit[i] && sp) cs = 1;
      r[i] = '0;
      if (!s_vld[i]) d[i] = 0;
      else if (sp || so) d[i] = 2;
      else if (s_op[i] && s_miss[i]) d[i] = 3;
      else begin
        d[i] = 1;
        r[i] = s_op[i] ? s_ld[i] : DW'(m_val[s_rs1[i]] + m_val[s_rs2[i]]);
      end
    end
    ok = !cs && (DEPTH - mq.size() >= GW);
    chk(grp_ready == ok, req, "grp_ready", 64'(grp_ready), 64'(ok));
    chk(q_valid == (mq.size() != 0), {req, " R8"}, "q_valid", 64'(q_valid), 64'(mq.size() != 0));
    if (mq.size() != 0)
      chk(q_entry == mq[0], {req, " R8"}, "q_entry", 64'(q_entry), 64'(mq[0]));
    if (q_pop && mq.size() != 0) void'(mq.pop_front());
    if (fill_valid && m_pend[fill_reg]) begin
      m_pend[fill_reg] = 0;
      m_val[fill_reg]  = fill_data;
    end
    if (grp_valid && ok) begin
      for (int i = 0; i < GW; i++) begin
        if (d[i] != 0) begin
          mq.push_back({s_op[i], s_rd[i], s_rs1[i], s_rs2[i], (d[i] != 1), r[i]});
          if (d[i] == 1) begin
            m_val[s_rd[i]] = r[i]; m_pend[s_rd[i]] = 0; m_pois[s_rd[i]] = 0;
          end else if (d[i] == 2) begin
            m_pend[s_rd[i]] = 0; m_pois[s_rd[i]] = 1;
          end else begin
            m_pend[s_rd[i]] = 1; m_pois[s_rd[i]] = 0;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pk;
    for (int i = 0; i < NREG; i++) begin
      m_val[i] = '0; m_pend[i] = 0; m_pois[i] = 0;
    end
    clr_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9: empty FIFO, everything usable
    #1;
    chk(q_valid == 0, "R9", "q_valid after reset", 64'(q_valid), 64'd0);
    chk(grp_ready == 1, "R9", "grp_ready after reset", 64'(grp_ready), 64'd1);
    clr_inputs(); put(0, 0, 3, 1, 2, 1, 0, 0); step("R9");

    // R1: load hits and an add
    clr_inputs(); put(0, 1, 1, 0, 0, 0, 0, 5); put(1, 1, 2, 0, 0, 0, 0, 7); step("R1");
    clr_inputs(); put(0, 0, 3, 1, 2, 0, 0, 0); step("R1");
    // R5: missing load makes r4 pending
    clr_inputs(); put(0, 1, 4, 0, 0, 0, 1, 0); step("R5");
    // R2 and R6: slot0 deferred on r4, slot1 reads old r5 and executes
    clr_inputs(); put(0, 0, 5, 4, 1, 0, 0, 0); put(1, 0, 6, 5, 1, 0, 0, 0); step("R2 R6");
    // R3: consumer of poisoned r5 is deferred
    clr_inputs(); put(0, 0, 6, 5, 1, 0, 0, 0); step("R3");
    // R4: critical on pending r4 stalls the group
    clr_inputs(); put(0, 0, 7, 4, 1, 1, 0, 0); put(1, 1, 2, 0, 0, 0, 0, 9);
    #1; chk(grp_ready == 0, "R4", "critical stall", 64'(grp_ready), 64'd0);
    step("R4"); step("R4");
    fill_valid = 1; fill_reg = 3'd4; fill_data = 16'd9; step("R5");
    fill_valid = 0; step("R4 R5");
    // R4: critical on poisoned-only source is deferred
    clr_inputs(); put(0, 0, 7, 5, 1, 1, 0, 0); step("R4");
    // R10: fill and group write collide on r2
    clr_inputs(); put(0, 1, 2, 0, 0, 0, 1, 0); step("R10");
    clr_inputs(); put(0, 1, 2, 0, 0, 0, 0, 11);
    fill_valid = 1; fill_reg = 3'd2; fill_data = 16'd3; step("R10");
    clr_inputs(); put(0, 0, 3, 2, 0, 0, 0, 0); step("R10");
    // R6: same destination twice, higher slot wins
    clr_inputs(); put(0, 1, 1, 0, 0, 0, 0, 1); put(1, 1, 1, 0, 0, 0, 0, 2); step("R6");
    clr_inputs(); put(0, 0, 3, 1, 0, 0, 0, 0); step("R6");
    // R5: fill of a register that is not pending is ignored
    clr_inputs(); fill_valid = 1; fill_reg = 3'd1; fill_data = 16'hBEEF; step("R5");
    clr_inputs(); put(0, 0, 3, 1, 0, 0, 0, 0); step("R5");
    // R7: backpressure with pops withheld
    for (int k = 0; k < 4; k++) begin
      clr_inputs(); q_pop = 0; put(0, 0, 6, 1, 2, 0, 0, 0); put(1, 0, 7, 3, 1, 0, 0, 0);
      step("R7");
    end
    for (int k = 0; k < 6; k++) begin clr_inputs(); step("R7 R8"); end

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      clr_inputs();
      grp_valid = ($urandom_range(0, 9) < 8);
      for (int i = 0; i < GW; i++) begin
        s_vld[i] = ($urandom_range(0, 9) < 8);
        s_op[i] = $urandom_range(0, 1);
        s_rd[i] = RW'($urandom_range(0, NREG - 1));
        s_rs1[i] = RW'($urandom_range(0, NREG - 1));
        s_rs2[i] = RW'($urandom_range(0, NREG - 1));
        s_crit[i] = ($urandom_range(0, 3) == 0);
        s_miss[i] = ($urandom_range(0, 3) == 0);
        s_ld[i] = DW'($urandom);
      end
      q_pop = $urandom_range(0, 1);
      if ($urandom_range(0, 9) < 4) begin
        pk = $urandom_range(0, NREG - 1);
        for (int j = 0; j < NREG; j++)
          if (m_pend[(pk + j) % NREG]) begin pk = (pk + j) % NREG; break; end
        fill_valid = 1; fill_reg = RW'(pk); fill_data = DW'($urandom);
      end
      step("R1-mix R2-mix R4-mix");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule